// File: doc/BRIEF.md
# Exception Target Level Selector

This block decides where an incoming exception is taken in a four-level privilege model. Level 0 is the least privileged and level 3 the most. The inputs are the current level, the security state, the exception class, one routing bit per asynchronous class toward level 2 and another toward level 3, and a per-level execution-width setting. From these the block computes the target level and the width that level runs at. It also flags width settings that are inconsistent across levels.

The same strobe also checks a proposed exception return. A return may not climb in level, may not land on a level that is absent, and may not widen the execution width.

Levels 2 and 3 are optional, and parameters select which of them exist. A third parameter chooses between a purely combinational result and a result captured into a register on the strobe.

Top module: `exc_route_sel`

## Requirements
- R1: With the output register enabled, reset clears `valid_o`, `tgt_lvl_o`, `tgt_wide_o`, `cfg_illegal_o` and `ret_illegal_o` to 0.
- R2: A synchronous exception (class code 0) is taken at the current level, or at level 1 when the current level is 0. Its routing bits are ignored, and no exception ever targets level 0.
- R3: The target level is never lower than the current level. When routing selects a lower level, the exception is taken at the current level.
- R4: For IRQ, FIQ and system error (class codes 1, 2 and 3), routing bit index class-1 applies. A set bit in `route_mon_i` selects level 3 and takes priority over `route_hyp_i`, which selects level 2. With neither bit set, the routed level is 1.
- R5: In the secure state (`secure_i`=1) level 2 does not exist. `route_hyp_i` then has no effect and no exception targets level 2.
- R6: If the routed level is not present, the target falls back to the highest present level below it, and is then raised to at least the current level.
- R7: `tgt_wide_o` equals bit n of `wide_lvl_i`, where n is the target level and 1 means 64-bit.
- R8: `cfg_illegal_o` is set when the current level is not present, or when a present level running 32-bit sits above a present level running 64-bit.
- R9: `ret_illegal_o` is set when `ret_lvl_i` is above the current level, when `ret_lvl_i` is not present, or when `ret_wide_i`=1 while the current level runs 32-bit.
- R10: With the output register enabled, results are captured on a cycle with `valid_i` high, `valid_o` pulses one cycle later, and the outputs hold while `valid_i` is low. Without the register, the outputs follow the inputs and `valid_o` equals `valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Evaluation strobe |
| cur_lvl_i | input | 2 | Current privilege level |
| secure_i | input | 1 | 1 = secure state |
| cls_i | input | 2 | Class: 0 sync, 1 IRQ, 2 FIQ, 3 system error |
| route_hyp_i | input | 3 | Per-class routing to level 2 (bit = class-1) |
| route_mon_i | input | 3 | Per-class routing to level 3 (bit = class-1) |
| wide_lvl_i | input | 4 | Bit n = 1: level n runs 64-bit |
| ret_lvl_i | input | 2 | Level proposed by a return |
| ret_wide_i | input | 1 | Width proposed by a return, 1 = 64-bit |
| valid_o | output | 1 | Result valid |
| tgt_lvl_o | output | 2 | Target level |
| tgt_wide_o | output | 1 | Target width, 1 = 64-bit |
| cfg_illegal_o | output | 1 | Inconsistent level or width setting |
| ret_illegal_o | output | 1 | Proposed return is illegal |

## Verification
The bench builds three instances that share all inputs. The first has every level present and the output register enabled, so it reaches reset, capture and hold. The second has neither optional level and no register, so routing to level 2 or 3 must fall back to level 1. The third has level 2 but not level 3, so routing to level 3 must land on level 2 in the non-secure state and on level 1 in the secure state. A sweep over every current level, security state, class and routing bit pattern compares all three instances against a model built from the requirements.

// File: rtl/exc_route_pkg.sv
package exc_route_pkg;
  localparam int LVL_W     = 2;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int NUM_ROUTE = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    EXC_SYNC = 2'd0,
    EXC_IRQ  = 2'd1,
    EXC_FIQ  = 2'd2,
    EXC_SERR = 2'd3
  } exc_cls_e;

  // level exists in the given security state for this build
  function automatic logic lvl_present(lvl_t lvl, logic sec, bit has_l2, bit has_l3);
    case (lvl)
      2'd2:    lvl_present = has_l2 && !sec;
      2'd3:    lvl_present = has_l3;
      default: lvl_present = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/exc_lvl_resolve.sv
module exc_lvl_resolve
  import exc_route_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chk_i,
  input  lvl_t                 cur_lvl_i,
  input  logic                 secure_i,
  input  exc_cls_e             cls_i,
  input  logic [NUM_ROUTE-1:0] to_hyp_i,
  input  logic [NUM_ROUTE-1:0] to_mon_i,
  output lvl_t                 tgt_lvl_o
);
  logic sel_mon, sel_hyp;
  lvl_t routed, fallen, floor_lvl;

  always_comb begin
    sel_mon = 1'b0;
    sel_hyp = 1'b0;
    case (cls_i)
      EXC_IRQ:  begin sel_mon = to_mon_i[0]; sel_hyp = to_hyp_i[0]; end
      EXC_FIQ:  begin sel_mon = to_mon_i[1]; sel_hyp = to_hyp_i[1]; end
      EXC_SERR: begin sel_mon = to_mon_i[2]; sel_hyp = to_hyp_i[2]; end
      default:  ;
    endcase
  end

  always_comb begin
    if (sel_mon)                   routed = 2'd3;
    else if (sel_hyp && !secure_i) routed = 2'd2;
    else                           routed = 2'd1;
  end

  // step down past absent levels
  always_comb begin
    fallen = routed;
    if (fallen == 2'd3 && !lvl_present(2'd3, secure_i, HAS_L2, HAS_L3)) fallen = 2'd2;
    if (fallen == 2'd2 && !lvl_present(2'd2, secure_i, HAS_L2, HAS_L3)) fallen = 2'd1;
  end

  assign floor_lvl = (cur_lvl_i == 2'd0) ? 2'd1 : cur_lvl_i;
  assign tgt_lvl_o = (fallen > floor_lvl) ? fallen : floor_lvl;

  logic cur_ok;
  assign cur_ok = lvl_present(cur_lvl_i, secure_i, HAS_L2, HAS_L3);

  p_never_l0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_i |-> (tgt_lvl_o != 2'd0));
  p_no_descend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_i |-> (tgt_lvl_o >= cur_lvl_i));
  p_sec_no_l2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && secure_i && cur_ok) |-> (tgt_lvl_o != 2'd2));
  p_tgt_present_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && cur_ok) |-> lvl_present(tgt_lvl_o, secure_i, HAS_L2, HAS_L3));
endmodule

// File: rtl/exc_width_chk.sv
module exc_width_chk
  import exc_route_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  lvl_t               cur_lvl_i,
  input  logic               secure_i,
  input  logic [NUM_LVL-1:0] wide_lvl_i,
  input  lvl_t               ret_lvl_i,
  input  logic               ret_wide_i,
  output logic               cfg_bad_o,
  output logic               ret_bad_o
);
  logic [NUM_LVL-1:0] pres;
  logic               hier_bad;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_pres
    assign pres[g] = lvl_present(lvl_t'(g), secure_i, HAS_L2, HAS_L3);
  end

  // a 32-bit level may not host a 64-bit level below it
  always_comb begin
    hier_bad = 1'b0;
    for (int hi = 1; hi < NUM_LVL; hi++) begin
      for (int lo = 0; lo < hi; lo++) begin
        if (pres[hi] && pres[lo] && !wide_lvl_i[hi] && wide_lvl_i[lo]) hier_bad = 1'b1;
      end
    end
  end

  assign cfg_bad_o = hier_bad || !pres[cur_lvl_i];
  assign ret_bad_o = (ret_lvl_i > cur_lvl_i) || !pres[ret_lvl_i]
                   || (ret_wide_i && !wide_lvl_i[cur_lvl_i]);
endmodule

// File: rtl/exc_route_sel.sv
module exc_route_sel
  import exc_route_pkg::*;
#(
  parameter bit HAS_L2  = 1'b1,
  parameter bit HAS_L3  = 1'b1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] cur_lvl_i,
  input  logic       secure_i,
  input  logic [1:0] cls_i,
  input  logic [2:0] route_hyp_i,
  input  logic [2:0] route_mon_i,
  input  logic [3:0] wide_lvl_i,
  input  logic [1:0] ret_lvl_i,
  input  logic       ret_wide_i,
  output logic       valid_o,
  output logic [1:0] tgt_lvl_o,
  output logic       tgt_wide_o,
  output logic       cfg_illegal_o,
  output logic       ret_illegal_o
);
  lvl_t tgt_c;
  logic wide_c, cfg_c, ret_c;

  exc_lvl_resolve #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) i_resolve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_i     (valid_i),
    .cur_lvl_i (cur_lvl_i),
    .secure_i  (secure_i),
    .cls_i     (exc_cls_e'(cls_i)),
    .to_hyp_i  (route_hyp_i),
    .to_mon_i  (route_mon_i),
    .tgt_lvl_o (tgt_c)
  );

  exc_width_chk #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) i_width (
    .cur_lvl_i  (cur_lvl_i),
    .secure_i   (secure_i),
    .wide_lvl_i (wide_lvl_i),
    .ret_lvl_i  (ret_lvl_i),
    .ret_wide_i (ret_wide_i),
    .cfg_bad_o  (cfg_c),
    .ret_bad_o  (ret_c)
  );

  assign wide_c = wide_lvl_i[tgt_c];

  if (REG_OUT) begin : g_reg
    logic valid_q, wide_q, cfg_q, ret_q;
    lvl_t tgt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        tgt_q   <= '0;
        wide_q  <= 1'b0;
        cfg_q   <= 1'b0;
        ret_q   <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          tgt_q  <= tgt_c;
          wide_q <= wide_c;
          cfg_q  <= cfg_c;
          ret_q  <= ret_c;
        end
      end
    end

    assign valid_o       = valid_q;
    assign tgt_lvl_o     = tgt_q;
    assign tgt_wide_o    = wide_q;
    assign cfg_illegal_o = cfg_q;
    assign ret_illegal_o = ret_q;

    p_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(tgt_lvl_o) && $stable(tgt_wide_o)
                    && $stable(cfg_illegal_o) && $stable(ret_illegal_o)));
    p_no_descend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (tgt_lvl_o >= $past(cur_lvl_i)));
  end else begin : g_comb
    assign valid_o       = valid_i;
    assign tgt_lvl_o     = tgt_c;
    assign tgt_wide_o    = wide_c;
    assign cfg_illegal_o = cfg_c;
    assign ret_illegal_o = ret_c;
  end
endmodule

// File: tb/test_exc_route_sel.sv
`timescale 1ns/1ps
module test_exc_route_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] cur = '0;
  logic       sec = 1'b0;
  logic [1:0] cls = '0;
  logic [2:0] rh = '0;
  logic [2:0] rm = '0;
  logic [3:0] wide = 4'b1111;
  logic [1:0] rlvl = '0;
  logic       rwide = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] last_full = '0;

  always #2 clk = ~clk;

  logic       v_f, w_f, c_f, r_f, v_a, w_a, c_a, r_a, v_b, w_b, c_b, r_b;
  logic [1:0] t_f, t_a, t_b;

  exc_route_sel #(.HAS_L2(1'b1), .HAS_L3(1'b1), .REG_OUT(1'b1)) i_exc_route_sel (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cur_lvl_i(cur), .secure_i(sec),
    .cls_i(cls), .route_hyp_i(rh), .route_mon_i(rm), .wide_lvl_i(wide),
    .ret_lvl_i(rlvl), .ret_wide_i(rwide), .valid_o(v_f), .tgt_lvl_o(t_f),
    .tgt_wide_o(w_f), .cfg_illegal_o(c_f), .ret_illegal_o(r_f));

  exc_route_sel #(.HAS_L2(1'b0), .HAS_L3(1'b0), .REG_OUT(1'b0)) i_exc_route_sel_nol23 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cur_lvl_i(cur), .secure_i(sec),
    .cls_i(cls), .route_hyp_i(rh), .route_mon_i(rm), .wide_lvl_i(wide),
    .ret_lvl_i(rlvl), .ret_wide_i(rwide), .valid_o(v_a), .tgt_lvl_o(t_a),
    .tgt_wide_o(w_a), .cfg_illegal_o(c_a), .ret_illegal_o(r_a));

  exc_route_sel #(.HAS_L2(1'b1), .HAS_L3(1'b0), .REG_OUT(1'b0)) i_exc_route_sel_nol3 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cur_lvl_i(cur), .secure_i(sec),
    .cls_i(cls), .route_hyp_i(rh), .route_mon_i(rm), .wide_lvl_i(wide),
    .ret_lvl_i(rlvl), .ret_wide_i(rwide), .valid_o(v_b), .tgt_lvl_o(t_b),
    .tgt_wide_o(w_b), .cfg_illegal_o(c_b), .ret_illegal_o(r_b));

  function automatic bit pres(int l, bit h2, bit h3);
    if (l == 2) return h2 && !sec;
    if (l == 3) return h3;
    return 1'b1;
  endfunction

  // expected {tgt[1:0], wide, cfg_illegal, ret_illegal}
  function automatic logic [4:0] model(bit h2, bit h3);
    int r, fl, t;
    bit cb, rb;
    r = 1;
    if (cls != 2'd0) begin
      if (rm[cls-1]) r = 3;
      else if (rh[cls-1] && !sec) r = 2;
    end
    while (!pres(r, h2, h3)) r--;
    fl = (cur == 2'd0) ? 1 : int'(cur);
    t = (r > fl) ? r : fl;
    cb = !pres(cur, h2, h3);
    for (int hi = 1; hi < 4; hi++)
      for (int lo = 0; lo < hi; lo++)
        if (pres(hi, h2, h3) && pres(lo, h2, h3) && !wide[hi] && wide[lo]) cb = 1'b1;
    rb = (rlvl > cur) || !pres(rlvl, h2, h3) || (rwide && !wide[cur]);
    return {2'(t), wide[t], cb, rb};
  endfunction

  task automatic chk(input string req, input string inst, input logic [5:0] act,
                     input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cur=%0d sec=%0b cls=%0d rh=%b rm=%b wide=%b: act=%b exp=%b",
               req, inst, cur, sec, cls, rh, rm, wide, act, exp);
    end
  endtask

  // inputs already set at a negedge; strobe for one cycle
  task automatic apply(input string req);
    logic [4:0] e_f, e_a, e_b;
    e_f = model(1'b1, 1'b1);
    e_a = model(1'b0, 1'b0);
    e_b = model(1'b1, 1'b0);
    valid = 1'b1;
    #1;
    chk(req, "nol23", {v_a, t_a, w_a, c_a, r_a}, {1'b1, e_a});
    chk(req, "nol3",  {v_b, t_b, w_b, c_b, r_b}, {1'b1, e_b});
    @(negedge clk);
    valid = 1'b0;
    chk(req, "full",  {v_f, t_f, w_f, c_f, r_f}, {1'b1, e_f});
    last_full = e_f;
  endtask

  task automatic set_in(input logic [1:0] c, input logic s, input logic [1:0] k,
                        input logic [2:0] h, input logic [2:0] m);
    cur = c; sec = s; cls = k; rh = h; rm = m;
  endtask

  task automatic t_reset;
    chk("R1", "full", {v_f, t_f, w_f, c_f, r_f}, 6'b0);
  endtask

  task automatic t_sync;
    wide = 4'b1111; rlvl = 2'd0; rwide = 1'b0;
    for (int c = 0; c < 4; c++) begin
      set_in(2'(c), 1'b0, 2'd0, 3'b111, 3'b111);
      apply("R2 sync");
    end
  endtask

  task automatic t_routing;
    for (int k = 1; k < 4; k++) begin
      set_in(2'd0, 1'b0, 2'(k), 3'b000, 3'b000); apply("R4 none");
      set_in(2'd0, 1'b0, 2'(k), 3'(1 << (k-1)), 3'b000); apply("R4 hyp");
      set_in(2'd0, 1'b0, 2'(k), 3'b111, 3'(1 << (k-1))); apply("R4 mon priority");
      set_in(2'd0, 1'b0, 2'(k), 3'(~(1 << (k-1))), 3'(~(1 << (k-1)))); apply("R4 other bits");
    end
  endtask

  task automatic t_secure;
    set_in(2'd0, 1'b1, 2'd1, 3'b111, 3'b000); apply("R5 hyp ignored");
    set_in(2'd1, 1'b1, 2'd3, 3'b111, 3'b000); apply("R5 hyp ignored el1");
    set_in(2'd1, 1'b1, 2'd2, 3'b111, 3'b010); apply("R5 mon");
  endtask

  task automatic t_descend;
    set_in(2'd3, 1'b0, 2'd1, 3'b000, 3'b000); apply("R3 stay el3");
    set_in(2'd2, 1'b0, 2'd2, 3'b000, 3'b000); apply("R3 stay el2");
    set_in(2'd3, 1'b0, 2'd3, 3'b100, 3'b000); apply("R3 hyp below cur");
  endtask

  task automatic t_fallback;
    set_in(2'd0, 1'b0, 2'd1, 3'b000, 3'b001); apply("R6 mon fallback");
    set_in(2'd1, 1'b0, 2'd2, 3'b010, 3'b000); apply("R6 hyp fallback");
    set_in(2'd0, 1'b1, 2'd3, 3'b000, 3'b100); apply("R6 mon fallback secure");
  endtask

  task automatic t_width;
    wide = 4'b1110;
    set_in(2'd0, 1'b0, 2'd1, 3'b000, 3'b000); apply("R7 el1 wide");
    wide = 4'b1100;
    set_in(2'd0, 1'b0, 2'd2, 3'b010, 3'b000); apply("R7 el2 wide");
    set_in(2'd0, 1'b0, 2'd3, 3'b000, 3'b000); apply("R7 el1 narrow");
    wide = 4'b0000;
    set_in(2'd0, 1'b0, 2'd1, 3'b000, 3'b001); apply("R7 all narrow");
    wide = 4'b1111;
  endtask

  task automatic t_cfg;
    wide = 4'b0101;
    set_in(2'd0, 1'b0, 2'd0, 3'b000, 3'b000); apply("R8 narrow over wide");
    wide = 4'b1011;
    set_in(2'd0, 1'b0, 2'd0, 3'b000, 3'b000); apply("R8 el2 narrow");
    set_in(2'd0, 1'b1, 2'd0, 3'b000, 3'b000); apply("R8 el2 absent secure");
    wide = 4'b1111;
    set_in(2'd2, 1'b1, 2'd0, 3'b000, 3'b000); apply("R8 cur el2 secure");
    set_in(2'd3, 1'b0, 2'd0, 3'b000, 3'b000); apply("R8 cur el3");
  endtask

  task automatic t_ret;
    wide = 4'b1100;
    set_in(2'd2, 1'b0, 2'd0, 3'b000, 3'b000);
    rlvl = 2'd1; rwide = 1'b0; apply("R9 narrow ok");
    rlvl = 2'd1; rwide = 1'b1; apply("R9 keep wide ok");
    rlvl = 2'd3; rwide = 1'b0; apply("R9 climb");
    set_in(2'd1, 1'b0, 2'd0, 3'b000, 3'b000);
    rlvl = 2'd0; rwide = 1'b1; apply("R9 widen");
    set_in(2'd3, 1'b1, 2'd0, 3'b000, 3'b000);
    rlvl = 2'd2; rwide = 1'b0; apply("R9 absent secure");
    rlvl = 2'd0; rwide = 1'b0; wide = 4'b1111;
  endtask

  task automatic t_hold;
    set_in(2'd0, 1'b0, 2'd1, 3'b000, 3'b001);
    apply("R10 capture");
    set_in(2'd3, 1'b1, 2'd0, 3'b000, 3'b000);
    wide = 4'b0001; rlvl = 2'd3; rwide = 1'b1;
    @(negedge clk);
    chk("R10 hold", "full", {v_f, t_f, w_f, c_f, r_f}, {1'b0, last_full});
    chk("R10 comb valid", "nol23", {5'b0, v_a}, 6'b0);
    @(negedge clk);
    chk("R10 hold2", "full", {v_f, t_f, w_f, c_f, r_f}, {1'b0, last_full});
    wide = 4'b1111; rlvl = 2'd0; rwide = 1'b0;
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++)
          for (int h = 0; h < 8; h++)
            for (int m = 0; m < 8; m++) begin
              set_in(2'(c), 1'(s), 2'(k), 3'(h), 3'(m));
              wide = 4'((c * 5 + h) & 4'hF);
              rlvl = 2'(m); rwide = 1'(h);
              apply("R3 R6 sweep");
            end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_routing();
    t_secure();
    t_descend();
    t_fallback();
    t_width();
    t_cfg();
    t_ret();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule